// File: doc/BRIEF.md
# Floating-Point Underflow Exception Resolver

This block sits at the tail of a floating-point datapath. It takes a result that has not yet been rounded and turns it into the delivered single-precision value, together with its underflow, inexact, round-up and trap-request indications. The input carries a sign, a signed exponent with no range limit, and a normalized 24-bit significand. Below the significand sit a guard bit and a sticky bit.

Tininess is judged on the value rounded to full precision with an unbounded exponent. A tiny result then takes one of three paths. With the trap disabled, it is shifted into denormal form and rounded again. With the trap enabled, it keeps its full-precision rounding, gets a wrapped exponent and raises a trap request. With flush-to-zero active, it is replaced by a signed zero. All outputs are registered, one cycle after the input, and qualified by a valid bit.

Top module: `fp_underflow_resolver`

## Requirements
- R1: The outputs appear exactly one clock after an input cycle, and out_valid copies in_valid. While out_valid is low, all four flags are low. A synchronous active-high reset clears every output.
- R2: Input format: in_sig[25:2] is the significand with its integer bit at position 25, in_sig[1] is guard and in_sig[0] is sticky. The value is in_sig[25:2]·2^(in_exp−23). in_rmode uses 0 for nearest-even, 1 for toward zero, 2 for toward +inf and 3 for toward −inf. A non-tiny result has out_exp = rounded exponent + 127 and a 24-bit out_sig that includes the integer bit. A carry out of rounding gives significand 0x800000 and an exponent one higher.
- R3: A non-zero result is tiny when its exponent after full-precision rounding is below −126. An unrounded exponent of −127 that rounds up to 2^−126 is therefore not tiny.
- R4: With the trap disabled and flush-to-zero off, a tiny result is shifted right by (−126 − in_exp) and then rounded in the selected mode. out_exp is 0, or 1 when the rounding reaches 2^−126.
- R5: With the trap disabled, underflow is raised only for a result that is both tiny and inexact. A tiny exact result raises no flag and is delivered as a denormal.
- R6: With the trap enabled, every tiny result raises underflow and out_trap. The delivered significand is the full-precision rounding.
- R7: On the trap path, out_exp holds (rounded exponent + 127) modulo 2^17 for a normal operation, and modulo 2^8 (upper bits zero) when in_packed is set.
- R8: out_inx is set when the rounding that produced the delivered value discarded a non-zero guard or sticky bit.
- R9: out_rnd_up is set exactly when that rounding added one to the significand LSB.
- R10: With flush-to-zero set and the trap disabled, a tiny result becomes a zero with the input sign, and out_unf and out_inx are both set. When the trap is enabled, the trap path takes precedence over flush-to-zero.
- R11: An all-zero in_sig passes through as a zero with the input sign and no flags, whatever the mode bits are.
- R12: The denormalizing shift saturates at 26 positions, so that a very small value leaves only a sticky bit. That bit can still round up to the smallest denormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_sign | input | 1 | Result sign |
| in_exp | input | 18 | Unbiased signed exponent, unbounded range |
| in_sig | input | 26 | Significand, guard bit, sticky bit |
| in_rmode | input | 2 | Rounding mode |
| in_trap_en | input | 1 | Underflow trap enable |
| in_ftz | input | 1 | Flush-to-zero enable |
| in_packed | input | 1 | Packed-parallel operation (8-bit wrap) |
| out_valid | output | 1 | Output qualifier |
| out_sign | output | 1 | Delivered sign |
| out_exp | output | 17 | Biased exponent (wrapped on trap path) |
| out_sig | output | 24 | Delivered significand with integer bit |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |
| out_rnd_up | output | 1 | Significand was incremented by rounding |
| out_trap | output | 1 | Underflow trap request |

## Verification
The bench targets values at the tininess boundary. An all-ones significand at exponent −127 rounds either out of the tiny range or into it, depending on the mode. A design that judged tininess before rounding would flag underflow in the first case. Tiny exact inputs are run with the trap both off and on; a design that merged the two underflow rules would flag the first or miss the second. Further cases cover deep underflow beyond the saturation point, the packed and normal exponent wraps, flush-to-zero against trap priority, and signed zero. Each of these exposes a missing sticky merge, a wrong modulus or a flag leaking onto zero.

// File: rtl/fpur_pkg.sv
package fpur_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_t;

  // Increment decision from mode, sign, lsb, guard and sticky
  function automatic logic round_inc(rmode_t m, logic sign, logic lsb, logic g, logic s);
    case (m)
      RM_NEAREST: round_inc = g & (s | lsb);
      RM_ZERO:    round_inc = 1'b0;
      RM_UP:      round_inc = ~sign & (g | s);
      default:    round_inc = sign & (g | s);
    endcase
  endfunction
endpackage

// File: rtl/fpur_round.sv
module fpur_round
  import fpur_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             g,
  input  logic             s,
  input  rmode_t           mode,
  input  logic             sign,
  output logic [SIG_W:0]   sum,
  output logic             inc,
  output logic             inexact
);
  always_comb begin
    inc     = round_inc(mode, sign, sig[0], g, s);
    sum     = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
    inexact = g | s;
  end
endmodule

// File: rtl/fpur_denorm.sv
module fpur_denorm #(
  parameter int SIG_W = 24,
  localparam int EXT_W = SIG_W + 2,
  localparam int SHW = $clog2(EXT_W + 1)
) (
  input  logic [EXT_W-1:0] ext,
  input  logic [SHW-1:0]   sh,
  output logic [SIG_W-1:0] sig,
  output logic             g,
  output logic             s
);
  logic [2*EXT_W-1:0] wide;
  logic [EXT_W-1:0]   hi;
  logic [EXT_W-1:0]   lo;

  always_comb begin
    wide = {ext, {EXT_W{1'b0}}} >> sh;
    hi   = wide[2*EXT_W-1:EXT_W];
    lo   = wide[EXT_W-1:0];
    sig  = hi[EXT_W-1:2];
    g    = hi[1];
    s    = hi[0] | (|lo);
  end
endmodule

// File: rtl/fp_underflow_resolver.sv
module fp_underflow_resolver
  import fpur_pkg::*;
#(
  parameter int SIG_W  = 24,
  parameter int EXP_W  = 18,
  parameter int EMIN   = -126,
  parameter int BIAS   = 127,
  parameter int WRAP_W = 17,
  parameter int PAR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sign,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [SIG_W+1:0]   in_sig,
  input  logic [1:0]         in_rmode,
  input  logic               in_trap_en,
  input  logic               in_ftz,
  input  logic               in_packed,
  output logic               out_valid,
  output logic               out_sign,
  output logic [WRAP_W-1:0]  out_exp,
  output logic [SIG_W-1:0]   out_sig,
  output logic               out_unf,
  output logic               out_inx,
  output logic               out_rnd_up,
  output logic               out_trap
);
  localparam int EXT_W = SIG_W + 2;
  localparam int SHW   = $clog2(EXT_W + 1);
  localparam logic signed [EXP_W:0] EMIN_S   = (EXP_W+1)'(EMIN);
  localparam logic signed [EXP_W:0] BIAS_S   = (EXP_W+1)'(BIAS);
  localparam logic signed [EXP_W:0] SHMAX_S  = (EXP_W+1)'(EXT_W);

  rmode_t mode;
  logic signed [EXP_W:0] e_in, e_rnd, diff, e_biased;
  logic                  is_zero, tiny, carry;
  logic [SIG_W:0]        sum_full, sum_den;
  logic                  inc_full, inc_den, inx_full, inx_den;
  logic [SIG_W-1:0]      sig_full, sig_den;
  logic                  g_den, s_den;
  logic [SHW-1:0]        sh;

  assign mode    = rmode_t'(in_rmode);
  assign e_in    = {in_exp[EXP_W-1], in_exp};
  assign is_zero = (in_sig == '0);

  // Full-precision rounding with unbounded exponent
  fpur_round #(.SIG_W(SIG_W)) full_rnd_i (
    .sig(in_sig[SIG_W+1:2]), .g(in_sig[1]), .s(in_sig[0]),
    .mode(mode), .sign(in_sign),
    .sum(sum_full), .inc(inc_full), .inexact(inx_full)
  );

  always_comb begin
    carry    = sum_full[SIG_W];
    sig_full = carry ? {1'b1, {(SIG_W-1){1'b0}}} : sum_full[SIG_W-1:0];
    e_rnd    = e_in + {{EXP_W{1'b0}}, carry};
    tiny     = !is_zero && (e_rnd < EMIN_S);
    e_biased = e_rnd + BIAS_S;
    diff     = EMIN_S - e_in;
    if (diff < 0)              sh = '0;
    else if (diff > SHMAX_S)   sh = SHW'(EXT_W);
    else                       sh = diff[SHW-1:0];
  end

  // Denormalize the exact value, then round again
  fpur_denorm #(.SIG_W(SIG_W)) den_i (
    .ext(in_sig), .sh(sh), .sig(sig_den), .g(g_den), .s(s_den)
  );

  fpur_round #(.SIG_W(SIG_W)) den_rnd_i (
    .sig(sig_den), .g(g_den), .s(s_den),
    .mode(mode), .sign(in_sign),
    .sum(sum_den), .inc(inc_den), .inexact(inx_den)
  );

  logic [WRAP_W-1:0] n_exp;
  logic [SIG_W-1:0]  n_sig;
  logic              n_unf, n_inx, n_rup, n_trap;

  always_comb begin
    n_exp  = e_biased[WRAP_W-1:0];
    n_sig  = sig_full;
    n_unf  = 1'b0;
    n_inx  = inx_full;
    n_rup  = inc_full;
    n_trap = 1'b0;
    if (is_zero) begin
      n_exp = '0;
      n_sig = '0;
      n_inx = 1'b0;
      n_rup = 1'b0;
    end else if (tiny && in_trap_en) begin
      n_unf  = 1'b1;
      n_trap = 1'b1;
      if (in_packed)
        n_exp = {{(WRAP_W-PAR_W){1'b0}}, e_biased[PAR_W-1:0]};
    end else if (tiny && in_ftz) begin
      n_exp = '0;
      n_sig = '0;
      n_unf = 1'b1;
      n_inx = 1'b1;
      n_rup = 1'b0;
    end else if (tiny) begin
      n_sig = sum_den[SIG_W-1:0];
      n_exp = {{(WRAP_W-1){1'b0}}, sum_den[SIG_W-1]};
      n_inx = inx_den;
      n_rup = inc_den;
      n_unf = inx_den;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sign   <= 1'b0;
      out_exp    <= '0;
      out_sig    <= '0;
      out_unf    <= 1'b0;
      out_inx    <= 1'b0;
      out_rnd_up <= 1'b0;
      out_trap   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_sign   <= in_sign;
      out_exp    <= n_exp;
      out_sig    <= n_sig;
      out_unf    <= in_valid & n_unf;
      out_inx    <= in_valid & n_inx;
      out_rnd_up <= in_valid & n_rup;
      out_trap   <= in_valid & n_trap;
    end
  end
endmodule

// File: rtl/fpur_chk.sv
module fpur_chk #(
  parameter int SIG_W  = 24,
  parameter int EXP_W  = 18,
  parameter int WRAP_W = 17,
  parameter int PAR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sign,
  input logic [SIG_W+1:0]  in_sig,
  input logic              in_trap_en,
  input logic              in_ftz,
  input logic              in_packed,
  input logic              out_valid,
  input logic              out_sign,
  input logic [WRAP_W-1:0] out_exp,
  input logic [SIG_W-1:0]  out_sig,
  input logic              out_unf,
  input logic              out_inx,
  input logic              out_rnd_up,
  input logic              out_trap
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_unf || out_inx || out_rnd_up || out_trap));

  a_r6_trap_source: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> ($past(in_trap_en) && out_unf));

  a_r5_unf_needs_inexact: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unf && !out_trap) |-> out_inx);

  a_r9_roundup_inexact: assert property (@(posedge clk) disable iff (rst)
    out_rnd_up |-> out_inx);

  a_r7_packed_wrap: assert property (@(posedge clk) disable iff (rst)
    (out_trap && $past(in_packed)) |-> (out_exp[WRAP_W-1:PAR_W] == '0));

  a_r10_flush_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unf && $past(in_ftz && !in_trap_en))
      |-> (out_sig == '0 && out_exp == '0 && !out_rnd_up));

  a_r11_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_sig == '0))
      |-> (!out_unf && !out_inx && !out_trap && out_sig == '0 && out_sign == $past(in_sign)));
endmodule

bind fp_underflow_resolver fpur_chk #(
  .SIG_W(SIG_W), .EXP_W(EXP_W), .WRAP_W(WRAP_W), .PAR_W(PAR_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_sig(in_sig),
  .in_trap_en(in_trap_en), .in_ftz(in_ftz), .in_packed(in_packed),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
  .out_unf(out_unf), .out_inx(out_inx), .out_rnd_up(out_rnd_up), .out_trap(out_trap)
);

// File: tb/fp_underflow_resolver_tb_top.sv
module fp_underflow_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic [17:0] in_exp = '0;
  logic [25:0] in_sig = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_trap_en = 1'b0, in_ftz = 1'b0, in_packed = 1'b0;
  logic        out_valid, out_sign, out_unf, out_inx, out_rnd_up, out_trap;
  logic [16:0] out_exp;
  logic [23:0] out_sig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_underflow_resolver dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp),
    .in_sig(in_sig), .in_rmode(in_rmode), .in_trap_en(in_trap_en), .in_ftz(in_ftz),
    .in_packed(in_packed), .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_sig(out_sig), .out_unf(out_unf), .out_inx(out_inx), .out_rnd_up(out_rnd_up),
    .out_trap(out_trap)
  );

  typedef struct packed {
    logic [1:0]  rm;
    logic        ftz, trap, pk, sign;
    logic [17:0] exp;
    logic [25:0] sig;
    logic        esign;
    logic [16:0] eexp;
    logic [23:0] esig;
    logic        eunf, einx, erup, etrap;
  } vec_t;

  localparam int NV = 17;
  localparam logic [95:0] VEC [NV] = '{
    {2'd0,4'b0000, 18'sd0,     {24'h800000,2'b00}, 1'b0,17'd127,   24'h800000, 4'b0000},
    {2'd0,4'b0000, 18'sd3,     {24'h800001,2'b10}, 1'b0,17'd130,   24'h800002, 4'b0110},
    {2'd0,4'b0000, 18'sd3,     {24'h800002,2'b10}, 1'b0,17'd130,   24'h800002, 4'b0100},
    {2'd1,4'b0000, -18'sd1,    {24'hFFFFFF,2'b11}, 1'b0,17'd126,   24'hFFFFFF, 4'b0100},
    {2'd2,4'b0000, 18'sd5,     {24'hFFFFFF,2'b01}, 1'b0,17'd133,   24'h800000, 4'b0110},
    {2'd3,4'b0001, 18'sd5,     {24'h800000,2'b01}, 1'b1,17'd132,   24'h800001, 4'b0110},
    {2'd0,4'b0000, -18'sd127,  {24'hFFFFFF,2'b10}, 1'b0,17'd1,     24'h800000, 4'b0110},
    {2'd1,4'b0000, -18'sd127,  {24'hFFFFFF,2'b10}, 1'b0,17'd0,     24'h7FFFFF, 4'b1100},
    {2'd0,4'b0000, -18'sd130,  {24'h800000,2'b00}, 1'b0,17'd0,     24'h080000, 4'b0000},
    {2'd0,4'b0100, -18'sd130,  {24'h800000,2'b00}, 1'b0,17'h1FFFD, 24'h800000, 4'b1001},
    {2'd0,4'b0110, -18'sd130,  {24'h800001,2'b11}, 1'b0,17'h000FD, 24'h800002, 4'b1111},
    {2'd0,4'b1001, -18'sd130,  {24'h800000,2'b00}, 1'b1,17'd0,     24'h000000, 4'b1100},
    {2'd0,4'b1101, 18'sd0,     {24'h000000,2'b00}, 1'b1,17'd0,     24'h000000, 4'b0000},
    {2'd2,4'b0000, -18'sd200,  {24'h800000,2'b00}, 1'b0,17'd0,     24'h000001, 4'b1110},
    {2'd0,4'b0000, -18'sd127,  {24'hFFFFFF,2'b00}, 1'b0,17'd1,     24'h800000, 4'b1110},
    {2'd0,4'b0000, -18'sd200,  {24'h800000,2'b00}, 1'b0,17'd0,     24'h000000, 4'b1100},
    {2'd1,4'b1100, -18'sd127,  {24'hFFFFFF,2'b10}, 1'b0,17'd0,     24'hFFFFFF, 4'b1101}
  };

  string tag [NV];

  initial begin
    tag[0]  = "R2 exact normal";
    tag[1]  = "R2 R9 nearest tie odd rounds up";
    tag[2]  = "R2 nearest tie even holds";
    tag[3]  = "R2 R8 toward zero truncates";
    tag[4]  = "R2 R9 toward +inf carry out";
    tag[5]  = "R2 toward -inf negative";
    tag[6]  = "R3 rounds out of tiny range";
    tag[7]  = "R4 R5 tiny inexact denormal";
    tag[8]  = "R5 tiny exact no flags";
    tag[9]  = "R6 R7 trap normal wrap 2^17";
    tag[10] = "R7 R8 R9 trap packed wrap 2^8";
    tag[11] = "R10 flush to signed zero";
    tag[12] = "R11 zero passes with sign";
    tag[13] = "R12 saturated shift rounds up";
    tag[14] = "R4 denormal rounds to min normal";
    tag[15] = "R12 R8 saturated shift to zero";
    tag[16] = "R10 trap has priority over flush";
  end

  task automatic check(string name, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", name, act, exp);
    end
  endtask

  function automatic logic [47:0] outs();
    return {4'b0, out_valid, out_sign, out_exp, out_sig, out_unf, out_inx, out_rnd_up, out_trap};
  endfunction

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 48'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      @(negedge clk);
      in_valid = 1'b1; in_rmode = v.rm; in_ftz = v.ftz; in_trap_en = v.trap;
      in_packed = v.pk; in_sign = v.sign; in_exp = v.exp; in_sig = v.sig;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag[i], outs(),
            {4'b0, 1'b1, v.esign, v.eexp, v.esig, v.eunf, v.einx, v.erup, v.etrap});
    end

    // R1: idle cycle with a tiny inexact input, flags must stay low
    in_valid = 1'b0; in_trap_en = 1'b1; in_exp = -18'sd140; in_sig = {24'h800001, 2'b11};
    @(negedge clk);
    check("R1 idle flags low", {44'b0, out_valid, out_unf, out_inx, out_trap}, 48'h0);

    // R1: back-to-back inputs each one cycle later
    in_valid = 1'b1; in_trap_en = 1'b0; in_ftz = 1'b0; in_rmode = 2'd0;
    in_sign = 1'b0; in_exp = 18'sd1; in_sig = {24'h800000, 2'b00};
    @(negedge clk);
    check("R1 first of pair", {31'b0, out_valid, out_exp}, {31'b0, 1'b1, 17'd128});
    in_exp = 18'sd2;
    @(negedge clk);
    check("R1 second of pair", {31'b0, out_valid, out_exp}, {31'b0, 1'b1, 17'd129});
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {47'b0, out_valid}, 48'h0);

    // R1: reset clears registered outputs
    in_valid = 1'b1; in_trap_en = 1'b1; in_exp = -18'sd140;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", outs(), 48'h0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule